// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

A synchronous binary counter slice, four bits wide by default, that counts up or down, takes a parallel preset, and gives an active-low terminal-count output so that several slices can be chained into a wider counter. All count bits change together on the rising clock edge. Two active-low enables must both be asserted for the slice to advance. The first, the parallel enable, only gates counting. The second, the trickle enable, also gates the carry output.

In a chain, every slice shares the clock, the load, the direction and the parallel enable. Each slice's trickle enable is driven by the carry output of the slice below it. The carry output is combinational from the stored count, the direction and the trickle enable. A slice therefore advances on the same edge on which every lower slice sits at its terminal value, and no external gating is needed. The block also has an active-low asynchronous reset to zero, which matches the reset style of the rest of the chip.

Top module: `updn_cnt_stage`

## Requirements
- R1: While rst_ni is low, q_o is 0 regardless of the clock.
- R2: If load_ni is low at a rising edge, q_o takes data_i at that edge. The enables and dir_up_i are ignored on that edge.
- R3: If load_ni is high and either par_en_ni or trk_en_ni is high at a rising edge, q_o keeps its value.
- R4: If load_ni is high, both enables are low and dir_up_i is 1 at a rising edge, q_o increments by one. It wraps from 15 to 0.
- R5: If load_ni is high, both enables are low and dir_up_i is 0 at a rising edge, q_o decrements by one. It wraps from 0 to 15.
- R6: carry_no is low exactly when trk_en_ni is low and q_o is at its terminal value: all ones when dir_up_i is 1, zero when dir_up_i is 0. It follows these inputs within the same cycle, with no register in the path.
- R7: carry_no is high whenever trk_en_ni is high, even when q_o is at its terminal value.
- R8: Two slices form an 8-bit counter when the low slice's carry_no drives the high slice's trk_en_ni and all other controls are shared. The chain counts through a full wrap in both directions, and the high slice's carry_no marks 255 when counting up and 0 when counting down.
- R9: Changes on load_ni, the enables, dir_up_i or data_i between rising edges leave q_o unchanged. Only the levels present at the edge decide the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the count |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | WIDTH | Parallel preset value |
| dir_up_i | input | 1 | 1 counts up, 0 counts down |
| par_en_ni | input | 1 | Parallel count enable, active low |
| trk_en_ni | input | 1 | Trickle count enable, active low; also gates carry_no |
| q_o | output | WIDTH | Current count |
| carry_no | output | 1 | Terminal-count carry, active low, combinational |

## Verification
Two things can fall in the same cycle: the carry of a slice that is at its terminal value, and the advance of the slice above it on the next edge. In a chain the upper slice's trickle enable is the lower slice's combinational carry. An error there shows up as an upper digit that steps one cycle late or early. The two-slice chain is run through a complete 8-bit wrap up and then down, and the concatenated count is compared on every cycle with an 8-bit model. A second coincidence, load against count, is provoked by random stimulus in which load is low while both enables are asserted, and the model expects the preset value.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_INC  = 2'd2,
    MODE_DEC  = 2'd3
  } mode_e;
endpackage

// File: rtl/updn_ctrl.sv
`timescale 1ns/1ps
module updn_ctrl
  import updn_pkg::*;
(
  input  logic  load_ni,
  input  logic  par_en_ni,
  input  logic  trk_en_ni,
  input  logic  dir_up_i,
  output mode_e mode_o
);
  // load wins over counting
  always_comb begin
    if (!load_ni)                     mode_o = MODE_LOAD;
    else if (par_en_ni || trk_en_ni)  mode_o = MODE_HOLD;
    else if (dir_up_i)                mode_o = MODE_INC;
    else                              mode_o = MODE_DEC;
  end
endmodule

// File: rtl/updn_next.sv
`timescale 1ns/1ps
module updn_next
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] data_i,
  input  mode_e            mode_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] Step = WIDTH'(1);

  always_comb begin
    unique case (mode_i)
      MODE_LOAD: nxt_o = data_i;
      MODE_INC:  nxt_o = q_i + Step;
      MODE_DEC:  nxt_o = q_i - Step;
      default:   nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
`timescale 1ns/1ps
module updn_term #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             dir_up_i,
  input  logic             trk_en_ni,
  output logic             carry_no
);
  logic [WIDTH-1:0] cmp;
  logic             at_term;

  // bitwise terminal match: all ones up, all zeros down
  for (genvar b = 0; b < WIDTH; b++) begin : g_cmp
    assign cmp[b] = ~(q_i[b] ^ dir_up_i);
  end

  assign at_term  = &cmp;
  assign carry_no = ~(at_term & ~trk_en_ni);
endmodule

// File: rtl/updn_cnt_stage.sv
`timescale 1ns/1ps
module updn_cnt_stage
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             dir_up_i,
  input  logic             par_en_ni,
  input  logic             trk_en_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_no
);
  mode_e            mode;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  updn_ctrl i_ctrl (
    .load_ni   (load_ni),
    .par_en_ni (par_en_ni),
    .trk_en_ni (trk_en_ni),
    .dir_up_i  (dir_up_i),
    .mode_o    (mode)
  );

  updn_next #(.WIDTH(WIDTH)) i_next (
    .q_i    (cnt_q),
    .data_i (data_i),
    .mode_i (mode),
    .nxt_o  (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  updn_term #(.WIDTH(WIDTH)) i_term (
    .q_i       (cnt_q),
    .dir_up_i  (dir_up_i),
    .trk_en_ni (trk_en_ni),
    .carry_no  (carry_no)
  );

  assign q_o = cnt_q;
endmodule

// File: rtl/updn_cnt_chk.sv
`timescale 1ns/1ps
module updn_cnt_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             dir_up_i,
  input logic             par_en_ni,
  input logic             trk_en_ni,
  input logic [WIDTH-1:0] q_o,
  input logic             carry_no
);
  localparam logic [WIDTH-1:0] One  = WIDTH'(1);
  localparam logic [WIDTH-1:0] Ones = '1;

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(data_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (par_en_ni || trk_en_ni)) |=> $stable(q_o));

  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !par_en_ni && !trk_en_ni && dir_up_i) |=> q_o == $past(q_o) + One);

  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !par_en_ni && !trk_en_ni && !dir_up_i) |=> q_o == $past(q_o) - One);

  p_carry_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trk_en_ni && dir_up_i && q_o == Ones) |-> !carry_no);

  p_carry_dn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trk_en_ni && !dir_up_i && q_o == '0) |-> !carry_no);

  p_carry_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (!trk_en_ni && (q_o == (dir_up_i ? Ones : '0))));

  p_carry_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trk_en_ni |-> carry_no);
endmodule

bind updn_cnt_stage updn_cnt_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_updn_cnt_stage.sv
`timescale 1ns/1ps
module test_updn_cnt_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_load_n = 1'b1, s_up = 1'b1, s_pe_n = 1'b1, s_te_n = 1'b1;
  logic [3:0] s_data = '0;
  logic [3:0] s_q;
  logic       s_carry_n;

  logic       c_load_n = 1'b1, c_up = 1'b1, c_en_n = 1'b1;
  logic [3:0] c_data = '0;
  logic [3:0] lo_q, hi_q;
  logic       lo_carry_n, hi_carry_n;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q;
  logic [7:0] exp8;

  always #2.5 clk = ~clk;

  updn_cnt_stage i_updn_cnt_stage (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(s_load_n), .data_i(s_data),
    .dir_up_i(s_up), .par_en_ni(s_pe_n), .trk_en_ni(s_te_n),
    .q_o(s_q), .carry_no(s_carry_n)
  );

  updn_cnt_stage i_lo (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(c_load_n), .data_i(c_data),
    .dir_up_i(c_up), .par_en_ni(c_en_n), .trk_en_ni(c_en_n),
    .q_o(lo_q), .carry_no(lo_carry_n)
  );

  updn_cnt_stage i_hi (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(c_load_n), .data_i(c_data),
    .dir_up_i(c_up), .par_en_ni(c_en_n), .trk_en_ni(lo_carry_n),
    .q_o(hi_q), .carry_no(hi_carry_n)
  );

  function automatic logic [3:0] f_next(logic [3:0] q, logic ld_n, logic [3:0] d,
                                        logic up, logic pe_n, logic te_n);
    if (!ld_n)             return d;
    if (pe_n || te_n)      return q;
    return up ? q + 4'd1 : q - 4'd1;
  endfunction

  function automatic logic f_carry(logic [3:0] q, logic up, logic te_n);
    return !(!te_n && (up ? (q == 4'hF) : (q == 4'h0)));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // call at negedge; drives, checks carry, clocks, checks count
  task automatic step(input logic ld_n, input logic [3:0] d, input logic up,
                      input logic pe_n, input logic te_n);
    s_load_n = ld_n; s_data = d; s_up = up; s_pe_n = pe_n; s_te_n = te_n;
    #1;
    chk(te_n ? "R7" : "R6", {7'd0, s_carry_n}, {7'd0, f_carry(exp_q, up, te_n)});
    @(posedge clk);
    exp_q = f_next(exp_q, ld_n, d, up, pe_n, te_n);
    @(negedge clk);
    if (!ld_n)              chk("R2", {4'd0, s_q}, {4'd0, exp_q});
    else if (pe_n || te_n)  chk("R3", {4'd0, s_q}, {4'd0, exp_q});
    else if (up)            chk("R4", {4'd0, s_q}, {4'd0, exp_q});
    else                    chk("R5", {4'd0, s_q}, {4'd0, exp_q});
  endtask

  task automatic chain_step();
    @(posedge clk);
    if (c_load_n) exp8 = c_up ? exp8 + 8'd1 : exp8 - 8'd1;
    @(negedge clk);
    chk("R8 count", {hi_q, lo_q}, exp8);
    chk("R8 carry", {7'd0, hi_carry_n},
        {7'd0, !(c_up ? (exp8 == 8'hFF) : (exp8 == 8'h00))});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog R1..: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c41));
    exp_q = '0;
    // R1: reset holds the count at zero across edges
    s_load_n = 1'b0; s_data = 4'hA;
    repeat (2) @(posedge clk);
    #1 chk("R1", {4'd0, s_q}, 8'h00);
    chk("R7", {7'd0, s_carry_n}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    s_load_n = 1'b1;

    // directed corners
    step(1'b0, 4'hE, 1'b0, 1'b0, 1'b0);   // R2 load overrides active count
    step(1'b1, 4'h0, 1'b1, 1'b0, 1'b0);   // R4 -> F
    step(1'b1, 4'h0, 1'b1, 1'b1, 1'b1);   // R7 at F, trickle off; R3 hold
    step(1'b1, 4'h0, 1'b1, 1'b0, 1'b0);   // R6 low at F, R4 wrap to 0
    step(1'b1, 4'h0, 1'b0, 1'b0, 1'b0);   // R6 low at 0 down, R5 wrap to F
    step(1'b1, 4'h0, 1'b0, 1'b1, 1'b0);   // R3 par enable off
    step(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);   // R3 trickle off
    step(1'b1, 4'h0, 1'b1, 1'b1, 1'b0);   // R6 up at F with par off

    // R9: wiggle controls between edges, count must not move
    s_load_n = 1'b0; s_data = 4'h3; #0.5;
    s_pe_n = 1'b0; s_te_n = 1'b0; s_up = 1'b0; #0.5;
    s_load_n = 1'b1; s_data = 4'h9;
    chk("R9", {4'd0, s_q}, {4'd0, exp_q});
    s_pe_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", {4'd0, s_q}, {4'd0, exp_q});

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] d;
      logic ld_n, up, pe_n, te_n;
      d    = 4'($urandom_range(0, 15));
      ld_n = ($urandom_range(0, 7) != 0);
      up   = 1'($urandom_range(0, 1));
      pe_n = ($urandom_range(0, 4) == 0);
      te_n = ($urandom_range(0, 4) == 0);
      step(ld_n, d, up, pe_n, te_n);
    end

    // R8: two-slice chain, clear by load, then full wrap up and down
    c_load_n = 1'b0; c_data = 4'h0; c_en_n = 1'b0; c_up = 1'b1;
    @(posedge clk);
    exp8 = 8'h00;
    @(negedge clk);
    c_load_n = 1'b1;
    chk("R8 count", {hi_q, lo_q}, 8'h00);
    for (int i = 0; i < 256; i++) chain_step();
    c_up = 1'b0;
    for (int i = 0; i < 256; i++) chain_step();
    c_en_n = 1'b1;
    #1 chk("R8 carry", {7'd0, hi_carry_n}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule